// File: doc/BRIEF.md
# Flash Command Unlock Sequencer

This block watches the write cycles a host issues to a flash bank and recognises the protected multi-cycle command sequences that alter the array or switch it into identification mode. Each command needs two unlock write cycles, each a fixed address/data pair, before its command byte. An erase needs a second pair of unlock cycles after its set-up byte. Any write that departs from the expected step discards the partial sequence. When a program or erase sequence completes, the block captures the target address and data. It then pulses a start strobe to the array and holds a busy flag for a parameterised number of clock cycles, which stands in for the internal program or erase time.

While busy, the block ignores every write cycle. A host may then run code from another memory and poll for completion. In identification mode, reads at two fixed locations return a manufacturer byte and a device byte. Any other address in that mode reads as zero.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, busy, arrayStart, idActive and idRdValid are 0 and opKind is 00.
- R2: Sequence addresses are matched on busAddr bits 14..0 only. Bits 17..15 may hold any value during the unlock and command cycles.
- R3: Byte program is four writes: AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then any address with any data. In the cycle after the fourth write, arrayStart is high for one cycle, arrayAddr and arrayData hold that write's address and data, and opKind reads 01.
- R4: busy rises in the cycle after the completing write and stays high for exactly the operation's cycle count: PGM_CYCLES, SECT_CYCLES or BANK_CYCLES. opKind keeps its value while busy is high and returns to 00 when busy falls.
- R5: Sector erase is six writes: AAh to 5555h, 55h to 2AAAh, 80h to 5555h, AAh to 5555h, 55h to 2AAAh, then 30h to any address. opKind becomes 10, and arrayAddr holds the full sixth-cycle address, whose bits 17..12 name the 4 KB sector.
- R6: Bank erase is the same six writes, except that the sixth is 10h to 5555h. opKind becomes 11.
- R7: A write whose address or data differs from the step the sequence expects returns the block to its idle step. No array operation starts unless a complete sequence is sent again from the beginning.
- R8: The three-write sequence ending with 90h to 5555h sets idActive. A read with idActive high and busy low raises idRdValid in the next cycle. idRdData is then BFh for address 0, DEV_ID for address 1, and 00h for any other address.
- R9: idActive clears after the three-write sequence ending with F0h to 5555h. It also clears after a single F0h write to any address whenever the block is neither busy nor waiting for program data.
- R10: While busy is high, every write is ignored. No operation starts, idActive does not change, and the sequence does not advance, so unlock cycles sent during busy count for nothing afterwards.
- R11: A read while idActive is low, or while busy is high, leaves idRdValid low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | A flash write cycle is present this clock |
| rdValid | input | 1 | A flash read cycle is present this clock |
| busAddr | input | 18 | Address of the current read or write |
| busWrData | input | 8 | Data of the current write |
| busy | output | 1 | Internal program or erase in progress |
| opKind | output | 2 | 00 none, 01 program, 10 sector erase, 11 bank erase |
| arrayStart | output | 1 | One-cycle pulse that starts the array operation |
| arrayAddr | output | 18 | Captured target address |
| arrayData | output | 8 | Captured data byte (the command byte for erases) |
| idActive | output | 1 | Identification mode is on |
| idRdValid | output | 1 | idRdData is valid this cycle |
| idRdData | output | 8 | Identification byte for the previous read |

## Verification
The assertions check every cycle for the following:
- a start pulse lasts one cycle and always falls inside busy;
- opKind is idle whenever busy is low;
- the captured address and data and idActive stay frozen through an operation;
- the busy timer never exceeds its longest load;
- identification data appears only after a read made in identification mode.

Only the bench scenarios can show the command grammar itself. This covers exact busy lengths per operation, mismatch aborts at the first and the second unlock, masking of the upper address bits, the two ways out of identification mode, and the fact that a sequence sent during busy leaves no trace.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int CMP_W = 15;
  localparam logic [CMP_W-1:0] UNLOCK_A = 15'h5555;
  localparam logic [CMP_W-1:0] UNLOCK_B = 15'h2AAA;
  localparam logic [7:0] KEY_A    = 8'hAA;
  localparam logic [7:0] KEY_B    = 8'h55;
  localparam logic [7:0] CMD_PGM  = 8'hA0;
  localparam logic [7:0] CMD_ERS  = 8'h80;
  localparam logic [7:0] CMD_IDIN = 8'h90;
  localparam logic [7:0] CMD_IDEX = 8'hF0;
  localparam logic [7:0] CMD_BANK = 8'h10;
  localparam logic [7:0] CMD_SECT = 8'h30;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PGM  = 2'b01,
    OP_SECT = 2'b10,
    OP_BANK = 2'b11
  } opKind_e;

  typedef struct packed {
    logic    start;
    opKind_e kind;
    logic    finish;
    logic    setId;
    logic    clrId;
  } seqStrb_t;
endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              timerZero,
  output seqStrb_t          strb,
  output logic              busy
);
  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PGMW, S_ERS1, S_ERS2, S_ERS3, S_BUSY
  } seqState_e;

  seqState_e state, nextState;
  logic isA, isB;

  assign isA = busAddr[CMP_W-1:0] == UNLOCK_A;
  assign isB = busAddr[CMP_W-1:0] == UNLOCK_B;
  assign busy = state == S_BUSY;

  always_comb begin
    nextState = state;
    strb = '0;
    strb.kind = OP_NONE;
    if (state == S_BUSY) begin
      if (timerZero) begin
        nextState = S_IDLE;
        strb.finish = 1'b1;
      end
    end else if (wrValid) begin
      nextState = S_IDLE;
      // A bare exit byte clears ID mode in every step except program data
      if (state != S_PGMW && busWrData == CMD_IDEX) strb.clrId = 1'b1;
      unique case (state)
        S_IDLE: if (isA && busWrData == KEY_A) nextState = S_UNL1;
        S_UNL1: if (isB && busWrData == KEY_B) nextState = S_UNL2;
        S_UNL2: if (isA) begin
          if (busWrData == CMD_PGM) nextState = S_PGMW;
          else if (busWrData == CMD_ERS) nextState = S_ERS1;
          else if (busWrData == CMD_IDIN) strb.setId = 1'b1;
        end
        S_PGMW: begin
          strb.start = 1'b1;
          strb.kind = OP_PGM;
          nextState = S_BUSY;
        end
        S_ERS1: if (isA && busWrData == KEY_A) nextState = S_ERS2;
        S_ERS2: if (isB && busWrData == KEY_B) nextState = S_ERS3;
        S_ERS3: if (isA && busWrData == CMD_BANK) begin
          strb.start = 1'b1;
          strb.kind = OP_BANK;
          nextState = S_BUSY;
        end else if (busWrData == CMD_SECT) begin
          strb.start = 1'b1;
          strb.kind = OP_SECT;
          nextState = S_BUSY;
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else state <= nextState;
  end

  AST_NO_START_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.start && !strb.setId && !strb.clrId); // R10
endmodule

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 8,
  parameter int PGM_CYCLES  = 16,
  parameter int SECT_CYCLES = 40,
  parameter int BANK_CYCLES = 64,
  parameter logic [DATA_W-1:0] MFR_ID = 8'hBF,
  parameter logic [DATA_W-1:0] DEV_ID = 8'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrb_t          strb,
  input  logic              busy,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic              timerZero,
  output logic [1:0]        opKind,
  output logic              arrayStart,
  output logic [ADDR_W-1:0] arrayAddr,
  output logic [DATA_W-1:0] arrayData,
  output logic              idActive,
  output logic              idRdValid,
  output logic [DATA_W-1:0] idRdData
);
  localparam int MAX_A = PGM_CYCLES > SECT_CYCLES ? PGM_CYCLES : SECT_CYCLES;
  localparam int MAX_C = MAX_A > BANK_CYCLES ? MAX_A : BANK_CYCLES;
  localparam int TMR_W = $clog2(MAX_C + 1);

  logic [TMR_W-1:0] tmrCnt, tmrLoad;
  opKind_e kindR;

  always_comb begin
    unique case (strb.kind)
      OP_SECT: tmrLoad = TMR_W'(SECT_CYCLES - 1);
      OP_BANK: tmrLoad = TMR_W'(BANK_CYCLES - 1);
      default: tmrLoad = TMR_W'(PGM_CYCLES - 1);
    endcase
  end

  assign timerZero = tmrCnt == '0;
  assign opKind = kindR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrCnt <= '0;
      kindR <= OP_NONE;
      arrayStart <= 1'b0;
      arrayAddr <= '0;
      arrayData <= '0;
      idActive <= 1'b0;
      idRdValid <= 1'b0;
      idRdData <= '0;
    end else begin
      arrayStart <= strb.start;
      if (strb.start) begin
        tmrCnt <= tmrLoad;
        kindR <= strb.kind;
        arrayAddr <= busAddr;
        arrayData <= busWrData;
      end else if (!timerZero) begin
        tmrCnt <= tmrCnt - 1'b1;
      end
      if (strb.finish) kindR <= OP_NONE;
      if (strb.setId) idActive <= 1'b1;
      else if (strb.clrId) idActive <= 1'b0;
      idRdValid <= rdValid && idActive && !busy;
      if (rdValid && idActive && !busy) begin
        if (busAddr[ADDR_W-1:1] != '0) idRdData <= '0;
        else idRdData <= busAddr[0] ? DEV_ID : MFR_ID;
      end
    end
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    arrayStart |=> !arrayStart); // R3
  AST_START_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    arrayStart |-> busy); // R4
  AST_IDLE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> opKind == OP_NONE); // R4
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !arrayStart) |-> $stable(arrayAddr) && $stable(arrayData)); // R10
  AST_ID_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(idActive)); // R10
  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    tmrCnt <= TMR_W'(MAX_C - 1)); // R4
  AST_IDRD_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    idRdValid |-> $past(idActive) && !$past(busy)); // R11
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 8,
  parameter int PGM_CYCLES  = 16,
  parameter int SECT_CYCLES = 40,
  parameter int BANK_CYCLES = 64,
  parameter logic [DATA_W-1:0] MFR_ID = 8'hBF,
  parameter logic [DATA_W-1:0] DEV_ID = 8'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic              busy,
  output logic [1:0]        opKind,
  output logic              arrayStart,
  output logic [ADDR_W-1:0] arrayAddr,
  output logic [DATA_W-1:0] arrayData,
  output logic              idActive,
  output logic              idRdValid,
  output logic [DATA_W-1:0] idRdData
);
  seqStrb_t strb;
  logic timerZero;

  flash_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .busAddr(busAddr),
    .busWrData(busWrData), .timerZero(timerZero), .strb(strb), .busy(busy)
  );

  flash_seq_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PGM_CYCLES(PGM_CYCLES),
    .SECT_CYCLES(SECT_CYCLES), .BANK_CYCLES(BANK_CYCLES),
    .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .rdValid(rdValid),
    .busAddr(busAddr), .busWrData(busWrData), .timerZero(timerZero),
    .opKind(opKind), .arrayStart(arrayStart), .arrayAddr(arrayAddr),
    .arrayData(arrayData), .idActive(idActive), .idRdValid(idRdValid),
    .idRdData(idRdData)
  );
endmodule

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;
  localparam int PGM_N = 16;
  localparam int SECT_N = 40;
  localparam int BANK_N = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0, rdValid = 1'b0;
  logic [17:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic busy, arrayStart, idActive, idRdValid;
  logic [1:0] opKind;
  logic [17:0] arrayAddr;
  logic [7:0] arrayData, idRdData;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  flash_cmd_seq u_dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdValid(rdValid),
    .busAddr(busAddr), .busWrData(busWrData), .busy(busy), .opKind(opKind),
    .arrayStart(arrayStart), .arrayAddr(arrayAddr), .arrayData(arrayData),
    .idActive(idActive), .idRdValid(idRdValid), .idRdData(idRdData)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one write at a falling edge; return after the capturing edge.
  task automatic wr(input logic [17:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; wrValid = 1'b1;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic rd(input logic [17:0] a);
    busAddr = a; rdValid = 1'b1;
    @(negedge clk);
    rdValid = 1'b0;
  endtask

  task automatic unlock(input logic [17:0] hi);
    wr(hi | 18'h05555, 8'hAA);
    wr(hi | 18'h02AAA, 8'h55);
  endtask

  task automatic busyLen(input string req, input int exp);
    int n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(req, "busy length", n, exp);
    chk(req, "opKind after busy", opKind, 0);
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy, 0);
    chk("R1", "opKind", opKind, 0);
    chk("R1", "arrayStart", arrayStart, 0);
    chk("R1", "idActive", idActive, 0);
    chk("R1", "idRdValid", idRdValid, 0);
  endtask

  task automatic t_program();
    unlock(18'h0);
    wr(18'h05555, 8'hA0);
    wr(18'h1F0A5, 8'h3C);
    chk("R3", "arrayStart", arrayStart, 1);
    chk("R3", "arrayAddr", arrayAddr, 18'h1F0A5);
    chk("R3", "arrayData", arrayData, 8'h3C);
    chk("R3", "opKind", opKind, 1);
    @(negedge clk);
    chk("R3", "start pulse width", arrayStart, 0);
    chk("R4", "opKind held", opKind, 1);
    busyLen("R4", PGM_N - 1);
  endtask

  task automatic t_upperBits();
    unlock(18'h38000);
    wr(18'h25555, 8'hA0);
    wr(18'h00042, 8'h11);
    chk("R2", "start with high bits set", arrayStart, 1);
    busyLen("R2", PGM_N);
  endtask

  task automatic t_sector();
    unlock(18'h0);
    wr(18'h05555, 8'h80);
    unlock(18'h0);
    wr(18'h2B123, 8'h30);
    chk("R5", "opKind", opKind, 2);
    chk("R5", "sector bits", arrayAddr[17:12], 6'h2B);
    busyLen("R5", SECT_N);
  endtask

  task automatic t_bank();
    unlock(18'h0);
    wr(18'h05555, 8'h80);
    unlock(18'h0);
    wr(18'h05555, 8'h10);
    chk("R6", "opKind", opKind, 3);
    busyLen("R6", BANK_N);
  endtask

  task automatic t_abort();
    wr(18'h05555, 8'hAA);
    wr(18'h02AAB, 8'h55);
    wr(18'h05555, 8'hA0);
    wr(18'h00100, 8'h00);
    chk("R7", "bad first unlock start", arrayStart | busy, 0);
    unlock(18'h0);
    wr(18'h05555, 8'h80);
    wr(18'h05555, 8'hAA);
    wr(18'h02AAA, 8'h54);
    wr(18'h05555, 8'h10);
    chk("R7", "bad second unlock start", arrayStart | busy, 0);
    unlock(18'h0);
    wr(18'h05555, 8'h80);
    unlock(18'h0);
    wr(18'h05555, 8'h20);
    chk("R7", "bad erase byte start", arrayStart | busy, 0);
  endtask

  task automatic t_id();
    rd(18'h0);
    chk("R11", "read outside ID mode", idRdValid, 0);
    unlock(18'h0);
    wr(18'h05555, 8'h90);
    chk("R8", "idActive set", idActive, 1);
    rd(18'h0);
    chk("R8", "mfr valid", idRdValid, 1);
    chk("R8", "mfr byte", idRdData, 8'hBF);
    rd(18'h1);
    chk("R8", "dev byte", idRdData, 8'h18);
    rd(18'h2);
    chk("R8", "other addr byte", idRdData, 8'h00);
    unlock(18'h0);
    wr(18'h05555, 8'hF0);
    chk("R9", "exit by sequence", idActive, 0);
    unlock(18'h0);
    wr(18'h05555, 8'h90);
    wr(18'h12345, 8'hF0);
    chk("R9", "exit by single write", idActive, 0);
  endtask

  task automatic t_busyIgnore();
    unlock(18'h0);
    wr(18'h05555, 8'h90);
    unlock(18'h0);
    wr(18'h05555, 8'hA0);
    wr(18'h00010, 8'h77);
    unlock(18'h0);
    wr(18'h05555, 8'hF0);
    chk("R10", "idActive kept in busy", idActive, 1);
    rd(18'h0);
    chk("R11", "ID read in busy", idRdValid, 0);
    unlock(18'h0);
    wr(18'h05555, 8'hA0);
    chk("R10", "addr frozen", arrayAddr, 18'h00010);
    while (busy) @(negedge clk);
    wr(18'h00200, 8'h01);
    chk("R10", "no start after busy", arrayStart | busy, 0);
    wr(18'h00000, 8'hF0);
    chk("R9", "single exit", idActive, 0);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_upperBits();
    t_sector();
    t_bank();
    t_abort();
    t_id();
    t_busyIgnore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule